// File: doc/BRIEF.md
# Command Ring Walker

This block is the device side of a circular ring of command cells held in memory. Software programs the ring through a small register file: the byte address of the head cell, the number of cells, the byte address of a status record, a control word and a restart request. It then posts work by writing a producer index. The engine walks the posted cells one by one through a synchronous read port. It checks the XOR checksums of each cell's control word and descriptor, and moves a 24-bit consumer index forward. It reports each finished cell, or a checksum failure, through a status register and a one-cycle status record.

Every cell starts on a 128-byte boundary and holds four 64-bit words: a control word, the byte address of the next cell, a descriptor and a payload address. The engine reads only the first three; the payload is handled elsewhere. The memory port is word addressed, so a cell at byte address A starts at word A>>3. The last cell's next address points back to the head cell.

Top module: `cmd_ring_engine`

## Requirements
- R1: After reset the consumer index, producer index, checksum error field and FSM code (0 = idle) all read zero, the cell count reads the NUM_CELLS parameter, and full_o, mem_rd_o and wb_valid_o are low.
- R2: A 64-bit word passes its checksum when bits 63:56 equal the XOR of bytes 0 to 6. Control-register bit 28 enables the check on the control word and bit 29 the check on the descriptor. On a failure the engine sets status bit 28 (control word) or bit 29 (descriptor) and control bit 2, enters FSM code 5, and holds the consumer index until a restart.
- R3: When the producer index differs from the consumer index, the engine reads words cur, cur+1 and cur+2 of the current cell. It then moves to the cell named by the next-address word (byte address bits ADDR_W+2:3). It adds one to the consumer index per cell and stops in idle once the consumer index equals the producer index.
- R4: Both indices wrap by masking with the cell count minus one, so the consumer index after the last cell is zero.
- R5: full_o is high when the consumer index equals (producer index + 1) masked. A producer write while full_o is high is ignored, and the readback of the producer index is unchanged.
- R6: Writing 1 to bit 1 of the request register (offset 1) starts a restart. The bit reads 1 in the cycle after the write and 0 from the next cycle on. The restart returns the FSM to idle, clears both indices, the checksum error field and control bit 2, and reloads the current cell from the head address.
- R7: Each finished cell and each checksum halt gives a one-cycle wb_valid_o. In that cycle wb_addr_o is {high, low} of the status address (offsets 7, 8). wb_header_o has 0xFF in bits 7:0 and CHAIN_ID in bits 23:16. wb_desc_o uses the layout of status register 0.
- R8: A write to the head-address low register (offset 6) while the engine is idle makes the cell at that byte address the next one fetched.
- R9: With control bits 29:28 clear, cells with wrong checksums finish normally.
- R10: Register offsets: 0 control, 1 request, 2 producer index, 3 status (read only), 4 cell count, 5/6 head address high/low, 7/8 status address high/low. The control register keeps bit 1 restart-enable, bit 2 checksum error, bit 4 event enable, bits 9:8 queue id, bits 29:28 check enables and bits 31:30 cell-size code; its other bits read zero. Status register 0 is consumer index 23:0, FSM 27:24 and checksum error 29:28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| mem_rd_o | output | 1 | Cell memory read request |
| mem_addr_o | output | ADDR_W | Cell memory word address |
| mem_rdata_i | input | 64 | Read data, one cycle after the request |
| full_o | output | 1 | Ring full, posts refused |
| wb_valid_o | output | 1 | Status record valid |
| wb_addr_o | output | 64 | Status record byte address |
| wb_header_o | output | 64 | Status record header |
| wb_desc_o | output | 32 | Status record buffer descriptor |

## Verification
The bench builds the engine with four cells and an 8-bit word address. Index wraparound therefore comes after every fourth cell, and twelve posting rounds of one to three cells cross it several times. A ring with four cells also reaches the full condition after three posts while the engine sits halted. The small memory keeps the whole ring in a bench array, so every control-word fetch address can be compared with the expected cell order.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

  localparam int RING_IDX_W = 24;

  localparam logic [3:0] REG_CTRL    = 4'd0;
  localparam logic [3:0] REG_REQ     = 4'd1;
  localparam logic [3:0] REG_PI      = 4'd2;
  localparam logic [3:0] REG_STAT    = 4'd3;
  localparam logic [3:0] REG_CELLS   = 4'd4;
  localparam logic [3:0] REG_HEAD_HI = 4'd5;
  localparam logic [3:0] REG_HEAD_LO = 4'd6;
  localparam logic [3:0] REG_WB_HI   = 4'd7;
  localparam logic [3:0] REG_WB_LO   = 4'd8;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_CTRL = 4'd1,
    ST_NEXT = 4'd2,
    ST_DESC = 4'd3,
    ST_DONE = 4'd4,
    ST_HALT = 4'd5
  } walk_state_e;

  // byte 7 must equal the XOR of bytes 0..6
  function automatic logic sum_ok(input logic [63:0] w);
    logic [7:0] x;
    x = '0;
    for (int b = 0; b < 7; b++) x ^= w[b*8 +: 8];
    return x == w[63:56];
  endfunction

endpackage

// File: rtl/cmd_ring_regs.sv
module cmd_ring_regs
  import cmd_ring_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_CELLS = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [3:0]            addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic [RING_IDX_W-1:0] ci_i,
  input  walk_state_e           state_i,
  input  logic [1:0]            chk_err_i,
  output logic [RING_IDX_W-1:0] pi_o,
  output logic [RING_IDX_W-1:0] mask_o,
  output logic                  restart_o,
  output logic [ADDR_W-1:0]     head_o,
  output logic                  head_load_o,
  output logic [1:0]            chk_en_o,
  output logic [63:0]           wb_addr_o,
  output logic                  full_o
);

  logic                  restart_q, head_load_q;
  logic [RING_IDX_W-1:0] pi_q;
  logic [31:0]           cells_q, head_hi_q, head_lo_q, wb_hi_q, wb_lo_q;
  logic                  ren_q, xerr_q, evt_q;
  logic [1:0]            eqid_q, chk_en_q, csize_q;
  logic [RING_IDX_W-1:0] mask;

  assign mask   = cells_q[RING_IDX_W-1:0] - RING_IDX_W'(1);
  assign full_o = (ci_i == ((pi_q + RING_IDX_W'(1)) & mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      restart_q   <= 1'b0;
      head_load_q <= 1'b0;
      pi_q        <= '0;
      cells_q     <= 32'(NUM_CELLS);
      head_hi_q   <= '0;
      head_lo_q   <= '0;
      wb_hi_q     <= '0;
      wb_lo_q     <= '0;
      ren_q       <= 1'b0;
      xerr_q      <= 1'b0;
      evt_q       <= 1'b0;
      eqid_q      <= '0;
      chk_en_q    <= '0;
      csize_q     <= '0;
    end else begin
      restart_q   <= we_i && addr_i == REG_REQ && wdata_i[1];
      head_load_q <= we_i && addr_i == REG_HEAD_LO;
      if (we_i) begin
        case (addr_i)
          REG_CTRL: begin
            ren_q    <= wdata_i[1];
            xerr_q   <= wdata_i[2];
            evt_q    <= wdata_i[4];
            eqid_q   <= wdata_i[9:8];
            chk_en_q <= wdata_i[29:28];
            csize_q  <= wdata_i[31:30];
          end
          REG_PI:      if (!full_o) pi_q <= wdata_i[RING_IDX_W-1:0] & mask;
          REG_CELLS:   cells_q   <= wdata_i;
          REG_HEAD_HI: head_hi_q <= wdata_i;
          REG_HEAD_LO: head_lo_q <= wdata_i;
          REG_WB_HI:   wb_hi_q   <= wdata_i;
          REG_WB_LO:   wb_lo_q   <= wdata_i;
          default: ;
        endcase
      end
      if (chk_err_i != 2'b00) xerr_q <= 1'b1;
      if (restart_q) begin
        pi_q   <= '0;
        xerr_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (addr_i)
      REG_CTRL:    rdata_o = {csize_q, chk_en_q, 18'b0, eqid_q, 3'b0, evt_q, 1'b0, xerr_q, ren_q, 1'b0};
      REG_REQ:     rdata_o = {30'b0, restart_q, 1'b0};
      REG_PI:      rdata_o = {8'b0, pi_q};
      REG_STAT:    rdata_o = {2'b0, chk_err_i, state_i, ci_i};
      REG_CELLS:   rdata_o = cells_q;
      REG_HEAD_HI: rdata_o = head_hi_q;
      REG_HEAD_LO: rdata_o = head_lo_q;
      REG_WB_HI:   rdata_o = wb_hi_q;
      REG_WB_LO:   rdata_o = wb_lo_q;
      default:     rdata_o = '0;
    endcase
  end

  assign pi_o        = pi_q;
  assign mask_o      = mask;
  assign restart_o   = restart_q;
  assign head_o      = head_lo_q[ADDR_W+2:3];
  assign head_load_o = head_load_q;
  assign chk_en_o    = chk_en_q;
  assign wb_addr_o   = {wb_hi_q, wb_lo_q};

  a_r6_restart_self_clears : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_q && !(we_i && addr_i == REG_REQ)) |=> !restart_q);

  a_r5_full_post_refused : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_PI && full_o && !restart_q) |=> $stable(pi_q));

endmodule

// File: rtl/cmd_ring_walker.sv
module cmd_ring_walker
  import cmd_ring_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [RING_IDX_W-1:0] pi_i,
  input  logic [RING_IDX_W-1:0] mask_i,
  input  logic                  restart_i,
  input  logic [ADDR_W-1:0]     head_i,
  input  logic                  head_load_i,
  input  logic [1:0]            chk_en_i,
  output logic                  mem_rd_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  input  logic [63:0]           mem_rdata_i,
  output logic [RING_IDX_W-1:0] ci_o,
  output walk_state_e           state_o,
  output logic [1:0]            chk_err_o,
  output logic                  wb_valid_o
);

  walk_state_e           state_q;
  logic [RING_IDX_W-1:0] ci_q, ci_nx;
  logic [ADDR_W-1:0]     cur_q, nxt_q;
  logic [63:0]           ctrl_q;
  logic [1:0]            err_q, bad;
  logic                  wb_q;

  assign ci_nx = (ci_q + RING_IDX_W'(1)) & mask_i;
  // only meaningful in ST_DONE, where mem_rdata_i carries the descriptor
  assign bad   = {chk_en_i[1] & ~sum_ok(mem_rdata_i), chk_en_i[0] & ~sum_ok(ctrl_q)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ci_q    <= '0;
      cur_q   <= '0;
      nxt_q   <= '0;
      ctrl_q  <= '0;
      err_q   <= '0;
      wb_q    <= 1'b0;
    end else begin
      wb_q <= 1'b0;
      if (restart_i) begin
        state_q <= ST_IDLE;
        ci_q    <= '0;
        err_q   <= '0;
        cur_q   <= head_i;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (head_load_i)       cur_q   <= head_i;
            else if (pi_i != ci_q) state_q <= ST_CTRL;
          end
          ST_CTRL: state_q <= ST_NEXT;
          ST_NEXT: begin
            ctrl_q  <= mem_rdata_i;
            state_q <= ST_DESC;
          end
          ST_DESC: begin
            nxt_q   <= mem_rdata_i[ADDR_W+2:3];
            state_q <= ST_DONE;
          end
          ST_DONE: begin
            wb_q <= 1'b1;
            if (bad != 2'b00) begin
              err_q   <= bad;
              state_q <= ST_HALT;
            end else begin
              ci_q    <= ci_nx;
              cur_q   <= nxt_q;
              state_q <= (ci_nx == pi_i) ? ST_IDLE : ST_CTRL;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    mem_rd_o   = 1'b1;
    mem_addr_o = cur_q;
    case (state_q)
      ST_NEXT: mem_addr_o = cur_q + ADDR_W'(1);
      ST_DESC: mem_addr_o = cur_q + ADDR_W'(2);
      ST_CTRL: ;
      default: mem_rd_o = 1'b0;
    endcase
  end

  assign ci_o       = ci_q;
  assign state_o    = state_q;
  assign chk_err_o  = err_q;
  assign wb_valid_o = wb_q;

  a_r2_halt_holds : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT && !restart_i) |=> (state_q == ST_HALT && $stable(ci_q)));

  a_r4_ci_step_wraps : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && state_q != ST_DONE) |=> $stable(ci_q));

  a_r3_idle_when_caught_up : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && ci_q == pi_i && !restart_i) |=> state_q == ST_IDLE);

  a_r7_wb_follows_cell : assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_q |-> $past(state_q) == ST_DONE);

endmodule

// File: rtl/cmd_ring_engine.sv
module cmd_ring_engine
  import cmd_ring_pkg::*;
#(
  parameter int         ADDR_W    = 12,
  parameter int         NUM_CELLS = 32,
  parameter logic [7:0] CHAIN_ID  = 8'h03
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [63:0]       mem_rdata_i,
  output logic              full_o,
  output logic              wb_valid_o,
  output logic [63:0]       wb_addr_o,
  output logic [63:0]       wb_header_o,
  output logic [31:0]       wb_desc_o
);

  logic [RING_IDX_W-1:0] pi, mask, ci;
  logic                  restart, head_load;
  logic [ADDR_W-1:0]     head;
  logic [1:0]            chk_en, chk_err;
  walk_state_e           state;

  cmd_ring_regs #(.ADDR_W(ADDR_W), .NUM_CELLS(NUM_CELLS)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .ci_i        (ci),
    .state_i     (state),
    .chk_err_i   (chk_err),
    .pi_o        (pi),
    .mask_o      (mask),
    .restart_o   (restart),
    .head_o      (head),
    .head_load_o (head_load),
    .chk_en_o    (chk_en),
    .wb_addr_o   (wb_addr_o),
    .full_o      (full_o)
  );

  cmd_ring_walker #(.ADDR_W(ADDR_W)) u_walker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pi_i        (pi),
    .mask_i      (mask),
    .restart_i   (restart),
    .head_i      (head),
    .head_load_i (head_load),
    .chk_en_i    (chk_en),
    .mem_rd_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .ci_o        (ci),
    .state_o     (state),
    .chk_err_o   (chk_err),
    .wb_valid_o  (wb_valid_o)
  );

  assign wb_header_o = {40'b0, CHAIN_ID, 8'h00, 8'hFF};
  assign wb_desc_o   = {2'b0, chk_err, state, ci};

endmodule

// File: tb/cmd_ring_engine_test.sv
module cmd_ring_engine_test;

  localparam int BASE_W = 64;  // word address of cell 0 (byte 0x200)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mem_rd;
  logic [7:0]  mem_addr;
  logic [63:0] mem_q = '0;
  logic        full, wb_valid;
  logic [63:0] wb_addr, wb_header;
  logic [31:0] wb_desc;

  logic [63:0] mem [256];
  int n_cmp = 0, n_bad = 0, n_wb = 0, exp_cell = 0;
  logic [31:0] last_desc = '0;

  always #4 clk = ~clk;

  cmd_ring_engine #(.ADDR_W(8), .NUM_CELLS(4), .CHAIN_ID(8'h05)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mem_rd_o(mem_rd),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_q), .full_o(full),
    .wb_valid_o(wb_valid), .wb_addr_o(wb_addr), .wb_header_o(wb_header),
    .wb_desc_o(wb_desc));

  always @(posedge clk) if (mem_rd) mem_q <= mem[mem_addr];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] seal(input logic [55:0] body);
    logic [7:0] x = '0;
    for (int b = 0; b < 7; b++) x ^= body[b*8 +: 8];
    return {x, body};
  endfunction

  function automatic int cw(input int c);
    return BASE_W + 16 * c;
  endfunction

  task automatic build_ring();
    for (int c = 0; c < 4; c++) begin
      mem[cw(c)]     = seal(56'h2 | (56'(c) << 16));
      mem[cw(c) + 1] = 64'(32'h200 + 128 * ((c + 1) % 4));
      mem[cw(c) + 2] = seal((56'h9) | (56'(c + 1) << 8) | (56'(c + 3) << 32) | (56'h4 << 40));
      mem[cw(c) + 3] = 64'h1000 + 64'(c);
    end
  endtask

  // monitor: write-back records and control-word fetch order
  always @(negedge clk) begin
    if (rst_n && wb_valid) begin
      n_wb++;
      last_desc = wb_desc;
      chk("R7 header", wb_header, 64'h0000_0000_0005_00FF);
      chk("R7 address", wb_addr, 64'h0000_0001_0000_4000);
      if (wb_desc[29:28] == 2'b00) exp_cell = (exp_cell + 1) % 4;
    end
    if (rst_n && mem_rd && mem_addr[3:0] == 4'h0)
      chk("R3 fetch order", 64'(mem_addr), 64'(cw(exp_cell)));
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic settle();
    repeat (24) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int ci, wb0, pi_new;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    build_ring();
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(4'd3, v);  chk("R1 status", 64'(v), 64'h0);
    rd(4'd2, v);  chk("R1 producer", 64'(v), 64'h0);
    rd(4'd4, v);  chk("R1 cell count", 64'(v), 64'd4);
    chk("R1 full", 64'(full), 64'h0);
    chk("R1 mem_rd", 64'(mem_rd), 64'h0);
    chk("R1 wb_valid", 64'(wb_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // initialisation order
    wr(4'd0, 32'h0);
    wr(4'd7, 32'h1);
    wr(4'd8, 32'h4000);
    wr(4'd1, 32'h2);
    rd(4'd1, v);  chk("R6 restart bit set", 64'(v[1]), 64'h1);
    @(negedge clk);
    rd(4'd1, v);  chk("R6 restart bit cleared", 64'(v[1]), 64'h0);
    wr(4'd0, 32'h7FFF_02FA);
    rd(4'd0, v);  chk("R10 control readback", 64'(v), 64'h7000_0212);
    wr(4'd4, 32'd4);
    wr(4'd5, 32'h0);
    wr(4'd6, 32'h200);
    rd(4'd3, v);  chk("R10 status after init", 64'(v), 64'h0);

    // R3/R4 sweep of post sizes across several wraps
    ci = 0;
    for (int r = 0; r < 12; r++) begin
      wb0 = n_wb;
      pi_new = (ci + (r % 3) + 1) % 4;
      wr(4'd2, 32'(pi_new));
      settle();
      rd(4'd3, v);
      chk("R3 consumer index", 64'(v[23:0]), 64'(pi_new));
      chk("R3 idle", 64'(v[27:24]), 64'h0);
      chk("R4 wrap count", 64'(n_wb - wb0), 64'((r % 3) + 1));
      chk("R7 desc index", 64'(last_desc[23:0]), 64'(pi_new));
      ci = pi_new;
    end

    // R9 checks disabled: broken sums pass
    wr(4'd0, 32'h4000_0212);
    mem[cw(exp_cell)]     ^= 64'h0100_0000_0000_0000;
    mem[cw(exp_cell) + 2] ^= 64'h0100_0000_0000_0000;
    pi_new = (ci + 1) % 4;
    wr(4'd2, 32'(pi_new));
    settle();
    rd(4'd3, v);  chk("R9 cell completes", 64'(v), 64'(pi_new));
    ci = pi_new;
    build_ring();

    // R2 control-word check halts
    wr(4'd0, 32'h5000_0212);
    mem[cw(exp_cell)] ^= 64'h0100_0000_0000_0000;
    wb0 = n_wb;
    wr(4'd2, 32'((ci + 1) % 4));
    settle();
    rd(4'd3, v);
    chk("R2 halt code", 64'(v[27:24]), 64'h5);
    chk("R2 control error", 64'(v[29:28]), 64'h1);
    chk("R2 index held", 64'(v[23:0]), 64'(ci));
    rd(4'd0, v);  chk("R2 control bit2", 64'(v[2]), 64'h1);
    chk("R7 halt record", 64'(n_wb - wb0), 64'h1);
    chk("R7 halt desc error", 64'(last_desc[29:28]), 64'h1);

    // R5 full while halted
    wr(4'd2, 32'((ci + 2) % 4));
    chk("R5 not full", 64'(full), 64'h0);
    wr(4'd2, 32'((ci + 3) % 4));
    chk("R5 full", 64'(full), 64'h1);
    wr(4'd2, 32'(ci));
    rd(4'd2, v);  chk("R5 post refused", 64'(v), 64'((ci + 3) % 4));

    // R6 restart
    wr(4'd1, 32'h2);
    @(negedge clk);
    exp_cell = 0;
    rd(4'd3, v);  chk("R6 status cleared", 64'(v), 64'h0);
    rd(4'd2, v);  chk("R6 producer cleared", 64'(v), 64'h0);
    rd(4'd0, v);  chk("R6 control bit2 cleared", 64'(v[2]), 64'h0);
    chk("R6 not full", 64'(full), 64'h0);
    build_ring();

    // R2 descriptor check halts on second cell
    wr(4'd0, 32'h6000_0212);
    mem[cw(1) + 2] ^= 64'h0100_0000_0000_0000;
    wb0 = n_wb;
    wr(4'd2, 32'd2);
    settle();
    rd(4'd3, v);
    chk("R2 descriptor error", 64'(v), 64'h2500_0001);
    chk("R2 two records", 64'(n_wb - wb0), 64'h2);
    build_ring();

    // R8 head reload selects start cell
    wr(4'd1, 32'h2);
    @(negedge clk);
    wr(4'd6, 32'h300);
    @(negedge clk);
    exp_cell = 2;
    wr(4'd2, 32'd1);
    settle();
    rd(4'd3, v);  chk("R8 cell from new head", 64'(v), 64'h1);
    chk("R8 next cell", 64'(exp_cell), 64'h3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule